// File: doc/BRIEF.md
# Dual-Mode Signed Multiplier

This block is a hard multiplier tile. It takes two operand buses and works in one of two modes. In wide mode it forms one full product of the two buses. In pair mode it cuts each bus into a low half and a high half, and it multiplies the two low halves and the two high halves on their own. A sign input for each operand sets whether that operand is read as two's complement or as unsigned. Both halves in pair mode use the same two sign inputs.

An input register stage holds the operands, the sign inputs and the mode select. An output register stage holds the product. Each stage is chosen by a parameter and has its own clock enable. An asynchronous clear input zeroes every stage that is present, and so does the active-low reset. With both stages present the product appears two clocks after the operands are applied. With one stage it appears after one clock, and with none it appears in the same cycle.

Top module: `dual_mode_mult`

## Requirements
- R1: With `split_i` = 0 (wide mode), `prod_o` equals the product of the 18-bit `x_i` and the 18-bit `y_i`, reduced modulo 2^36.
- R2: With `split_i` = 1 (pair mode), `prod_o[17:0]` equals `x_i[8:0]`×`y_i[8:0]` and `prod_o[35:18]` equals `x_i[17:9]`×`y_i[17:9]`, each reduced modulo 2^18. The two half products do not affect each other.
- R3: When `x_sgn_i` = 1, the X operand (or each X half) is read as two's complement, and when it is 0 the operand is zero-extended. `y_sgn_i` does the same for Y. With both at 0 the result is the plain unsigned product.
- R4: With both register stages present (the default), a set of operands, sign inputs and mode applied before clock edge n appears on `prod_o` after edge n+1, so the latency is 2 cycles.
- R5: When `ce_in_i` = 0, the input stage keeps its old contents. When `ce_out_i` = 0, `prod_o` keeps its old value across the edge.
- R6: While `clr_i` = 1, both stages are zero and `prod_o` reads 0 at once, without waiting for a clock edge.
- R7: While `rst_ni` = 0, both stages are zero and `prod_o` reads 0.
- R8: The mode select moves through the input stage together with its operands, so changing the mode every cycle gives each product in the mode it was applied with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both register stages |
| rst_ni | input | 1 | Asynchronous active-low reset. Release it synchronously. |
| clr_i | input | 1 | Asynchronous active-high clear of all register stages |
| ce_in_i | input | 1 | Clock enable of the input stage |
| ce_out_i | input | 1 | Clock enable of the output stage |
| split_i | input | 1 | 0: one wide product; 1: two half-width products |
| x_sgn_i | input | 1 | 1: X is two's complement; 0: X is unsigned |
| y_sgn_i | input | 1 | 1: Y is two's complement; 0: Y is unsigned |
| x_i | input | 18 | Operand X |
| y_i | input | 18 | Operand Y |
| prod_o | output | 36 | Product, or two packed half products |

## Verification
The bench goes after the most negative operand squared, which gives +2^34. A design that sign-extends into too few bits returns a negative value there. It also drives mixed-sign operands whose MSB is set. A design that sign-extends the unsigned side gives a wrong magnitude for these. In pair mode it sets the low halves with their top bits high and the high halves with other values. Carries or sign bits that leak from one half product into the other then corrupt the neighbouring field. The remaining cases cover clearing between edges, holding each enable low by itself, and changing the mode every cycle. A design that skips the mode register, or that needs a clock to clear, then shows a product in the wrong mode or a stale non-zero value.

// File: rtl/dm_mult_pkg.sv
package dm_mult_pkg;

  typedef enum logic {
    MODE_WIDE = 1'b0,
    MODE_PAIR = 1'b1
  } mul_mode_e;

endpackage

// File: rtl/dm_pipe_reg.sv
module dm_pipe_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_n;

      always_comb begin
        q_n = en_i ? d_i : q_r;
      end

      always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
        if (!rst_ni) begin
          q_r <= '0;
        end else if (clr_i) begin
          q_r <= '0;
        end else begin
          q_r <= q_n;
        end
      end

      assign q_o = q_r;
    end else begin : g_thru
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/dm_mul_core.sv
module dm_mul_core #(
  parameter int W = 9
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           a_sgn_i,
  input  logic           b_sgn_i,
  output logic [2*W-1:0] p_o
);

  localparam int PW = 2 * W;

  logic              a_top;
  logic              b_top;
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;
  logic signed [PW-1:0] prod;

  always_comb begin
    a_top = a_sgn_i & a_i[W-1];
    b_top = b_sgn_i & b_i[W-1];
    a_ext = $signed({{W{a_top}}, a_i});
    b_ext = $signed({{W{b_top}}, b_i});
    prod  = a_ext * b_ext;
  end

  assign p_o = prod;

endmodule

// File: rtl/dual_mode_mult.sv
module dual_mode_mult #(
  parameter int OP_W    = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ce_in_i,
  input  logic              ce_out_i,
  input  logic              split_i,
  input  logic              x_sgn_i,
  input  logic              y_sgn_i,
  input  logic [OP_W-1:0]   x_i,
  input  logic [OP_W-1:0]   y_i,
  output logic [2*OP_W-1:0] prod_o
);
  import dm_mult_pkg::*;

  localparam int HALF_W = OP_W / 2;
  localparam int PROD_W = 2 * OP_W;
  localparam int HP_W   = 2 * HALF_W;
  localparam int PK_W   = 2 * OP_W + 3;

  logic [PK_W-1:0]   in_d;
  logic [PK_W-1:0]   in_q;
  logic [OP_W-1:0]   xq;
  logic [OP_W-1:0]   yq;
  logic              xs_q;
  logic              ys_q;
  mul_mode_e         mode_q;
  logic [PROD_W-1:0] wide_p;
  logic [HP_W-1:0]   half_p [2];
  logic [PROD_W-1:0] prod_d;

  assign in_d = {split_i, y_sgn_i, x_sgn_i, y_i, x_i};

  dm_pipe_reg #(.W(PK_W), .EN(IN_REG)) in_stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (ce_in_i),
    .d_i    (in_d),
    .q_o    (in_q)
  );

  always_comb begin
    xq     = in_q[OP_W-1:0];
    yq     = in_q[2*OP_W-1:OP_W];
    xs_q   = in_q[2*OP_W];
    ys_q   = in_q[2*OP_W+1];
    mode_q = mul_mode_e'(in_q[2*OP_W+2]);
  end

  dm_mul_core #(.W(OP_W)) wide_i (
    .a_i     (xq),
    .b_i     (yq),
    .a_sgn_i (xs_q),
    .b_sgn_i (ys_q),
    .p_o     (wide_p)
  );

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      dm_mul_core #(.W(HALF_W)) half_i (
        .a_i     (xq[h*HALF_W +: HALF_W]),
        .b_i     (yq[h*HALF_W +: HALF_W]),
        .a_sgn_i (xs_q),
        .b_sgn_i (ys_q),
        .p_o     (half_p[h])
      );
    end
  endgenerate

  always_comb begin
    if (mode_q == MODE_PAIR) begin
      prod_d = {half_p[1], half_p[0]};
    end else begin
      prod_d = wide_p;
    end
  end

  dm_pipe_reg #(.W(PROD_W), .EN(OUT_REG)) out_stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (ce_out_i),
    .d_i    (prod_d),
    .q_o    (prod_o)
  );

endmodule

// File: rtl/dm_mult_chk.sv
module dm_mult_chk #(
  parameter int OP_W    = 18,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              ce_in_i,
  input logic              ce_out_i,
  input logic              split_i,
  input logic              x_sgn_i,
  input logic              y_sgn_i,
  input logic [OP_W-1:0]   x_i,
  input logic [OP_W-1:0]   y_i,
  input logic [2*OP_W-1:0] prod_o
);

  localparam int HALF_W = OP_W / 2;
  localparam int HP_W   = 2 * HALF_W;

  // edges seen since the last reset or clear, saturating at 3
  logic [1:0] since_clr;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni) begin
      since_clr <= 2'd0;
    end else if (clr_i) begin
      since_clr <= 2'd0;
    end else if (since_clr != 2'd3) begin
      since_clr <= since_clr + 2'd1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_zero_R7 : assert (prod_o == '0);
    end
  end

  assert_clear_zero_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (prod_o == '0));

  generate
    if (OUT_REG) begin : g_out_chk
      assert_hold_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        ((since_clr != 2'd0) && !$past(ce_out_i)) |-> (prod_o == $past(prod_o)));
    end

    if (IN_REG && OUT_REG) begin : g_lat_chk
      assert_wide_zero_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        ((since_clr >= 2'd2) && $past(ce_in_i, 2) && $past(ce_out_i) &&
         !$past(split_i, 2) && ($past(x_i, 2) == '0)) |-> (prod_o == '0));

      assert_pair_low_zero_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        ((since_clr >= 2'd2) && $past(ce_in_i, 2) && $past(ce_out_i) &&
         $past(split_i, 2) && ($past(y_i[HALF_W-1:0], 2) == '0)) |-> (prod_o[HP_W-1:0] == '0));

      assert_mixed_sign_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        ((since_clr >= 2'd2) && $past(ce_in_i, 2) && $past(ce_out_i) &&
         !$past(split_i, 2) && $past(x_sgn_i, 2) && !$past(y_sgn_i, 2) &&
         !$past(x_i[OP_W-1], 2)) |-> !prod_o[2*OP_W-1]);
    end
  endgenerate

endmodule

bind dual_mode_mult dm_mult_chk #(
  .OP_W    (OP_W),
  .IN_REG  (IN_REG),
  .OUT_REG (OUT_REG)
) chk_i (.*);

// File: tb/dual_mode_mult_tb_top.sv
module dual_mode_mult_tb_top;

  localparam int  W   = 18;
  localparam int  H   = 9;
  localparam time TCK = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr_i = 1'b0;
  logic          ce_in_i = 1'b0;
  logic          ce_out_i = 1'b0;
  logic          split_i = 1'b0;
  logic          x_sgn_i = 1'b0;
  logic          y_sgn_i = 1'b0;
  logic [W-1:0]  x_i = '0;
  logic [W-1:0]  y_i = '0;
  logic [2*W-1:0] prod_o;

  int n_chk = 0;
  int n_err = 0;

  // behavioural model state
  logic [W-1:0]   m_x = '0, m_y = '0;
  logic           m_xs = 0, m_ys = 0, m_sp = 0;
  logic [2*W-1:0] m_out = '0;

  always #(TCK/2) clk_i = ~clk_i;

  dual_mode_mult dut_i (.*);

  function automatic longint opval(logic [W-1:0] v, int w, logic sgn);
    longint u;
    u = longint'(v) & ((longint'(1) <<< w) - 1);
    if (sgn && v[w-1]) return u - (longint'(1) <<< w);
    return u;
  endfunction

  function automatic logic [2*W-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b,
                                              logic as_, logic bs, logic sp);
    logic [2*W-1:0] r;
    longint p;
    if (!sp) begin
      p = opval(a, W, as_) * opval(b, W, bs);
      r = p[2*W-1:0];
    end else begin
      for (int h = 0; h < 2; h++) begin
        p = opval(W'(a >> (h*H)), H, as_) * opval(W'(b >> (h*H)), H, bs);
        r[h*2*H +: 2*H] = p[2*H-1:0];
      end
    end
    return r;
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (prod_o !== m_out) begin
      n_err++;
      $display("FAIL %s: prod_o=%h expected=%h", tag, prod_o, m_out);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk_i);
    if (rst_ni && !clr_i) begin
      if (ce_out_i) m_out = ref_prod(m_x, m_y, m_xs, m_ys, m_sp);
      if (ce_in_i) begin
        m_x = x_i; m_y = y_i; m_xs = x_sgn_i; m_ys = y_sgn_i; m_sp = split_i;
      end
    end
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic as_, logic bs,
                       logic sp, string tag);
    x_i = a; y_i = b; x_sgn_i = as_; y_sgn_i = bs; split_i = sp;
    tick(tag);
  endtask

  task automatic pulse_clear();
    #2ns clr_i = 1'b1;
    #1ns;
    m_x = '0; m_y = '0; m_xs = 0; m_ys = 0; m_sp = 0; m_out = '0;
    check("R6 async clear");
    #1ns clr_i = 1'b0;
  endtask

  initial begin
    #(TCK * 150000);
    n_err++;
    $display("FAIL watchdog: prod_o=%h expected=finish", prod_o);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) tick("R7 reset");
    rst_ni = 1'b1;
    ce_in_i = 1'b1; ce_out_i = 1'b1;

    // R4: latency, value 5*7 shows after the second edge
    apply(18'd5, 18'd7, 0, 0, 0, "R4 latency edge1");
    tick("R4 latency edge2");
    tick("R4 latency settle");

    // R1/R3 wide corners
    apply(18'h20000, 18'h20000, 1, 1, 0, "R1 min*min signed");
    apply(18'h3FFFF, 18'h3FFFF, 0, 0, 0, "R3 unsigned max");
    apply(18'h3FFFF, 18'h3FFFF, 1, 0, 0, "R3 x signed y unsigned");
    apply(18'h3FFFF, 18'h20001, 0, 1, 0, "R3 x unsigned y signed");
    apply(18'h1FFFF, 18'h3FFFF, 1, 1, 0, "R1 max*-1");
    apply(18'h12345, 18'h0ABCD, 1, 1, 0, "R1 positive");
    tick("R1 flush"); tick("R1 flush");

    // R2 pair mode
    apply({9'h100, 9'h1FF}, {9'h0FF, 9'h100}, 1, 1, 1, "R2 pair signed");
    apply({9'h100, 9'h1FF}, {9'h0FF, 9'h100}, 0, 0, 1, "R2 pair unsigned");
    apply({9'h1FF, 9'h001}, {9'h1FF, 9'h1FF}, 1, 0, 1, "R2 pair mixed");
    apply({9'h07F, 9'h100}, {9'h003, 9'h100}, 1, 1, 1, "R2 pair min*min");
    tick("R2 flush"); tick("R2 flush");

    // R8: mode alternates every cycle
    for (int i = 0; i < 6; i++)
      apply(18'h2A5C3 + 18'(i * 977), 18'h1F0E1 - 18'(i * 311), 1, i[1], i[0], "R8 mode toggle");
    tick("R8 flush"); tick("R8 flush");

    // R5: input enable low holds the stage while inputs move
    ce_in_i = 1'b0;
    apply(18'h00123, 18'h00456, 0, 0, 0, "R5 ce_in low");
    apply(18'h3F000, 18'h00FFF, 1, 1, 1, "R5 ce_in low");
    ce_in_i = 1'b1;
    apply(18'h00321, 18'h00654, 0, 0, 0, "R5 ce_in back");
    // output enable low holds prod_o
    ce_out_i = 1'b0;
    apply(18'h3FFFE, 18'h00002, 1, 1, 0, "R5 ce_out low");
    apply(18'h00011, 18'h00022, 0, 0, 0, "R5 ce_out low");
    ce_out_i = 1'b1;
    tick("R5 ce_out back"); tick("R5 ce_out back");

    // R6: clear between edges
    apply(18'h15555, 18'h0AAAA, 0, 0, 0, "R6 before clear");
    tick("R6 before clear");
    pulse_clear();
    tick("R6 after clear"); tick("R6 after clear");

    // mixed random traffic over all requirements
    for (int i = 0; i < 400; i++) begin
      ce_in_i  = ($urandom % 8) != 0;
      ce_out_i = ($urandom % 8) != 0;
      apply(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            "R1 R2 R3 R5 random");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule